// File: doc/BRIEF.md
# Adaptive Window Quantizer Controller

This block is the digital side of a two-comparator window quantizer that watches the feedback voltage of a switching regulator. On every sample strobe it takes the results of two comparators and turns them into a 2-bit error code. One comparator trips above the upper reference and the other trips above the lower reference. The code says whether the voltage sits below the window, inside it, or above it. The code goes to the loop compensator and into a short history shift register.

From that history the block drives a window-select line to the external reference multiplexer. After the voltage has stayed inside the window for a set number of samples, the select moves to the narrow reference pair, which tightens the ripple band. A single sample outside the window puts it back on the wide pair straight away. The multiplexer and references need a few clocks to settle, so a separate ready flag tells the compensator when the narrow window actually holds. A comparator pair that reports "above high but not above low" cannot occur physically. It is absorbed as in-window and recorded in a flag that stays set until reset.

Top module: `adwin_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the error code to 00, clears every history entry to 00, clears code_valid, win_narrow, narrow_ready and illegal_seen.
- R2: On a clock edge with sample_en high, err_code takes the code {above_hi, above_lo}: 00 means below the window, 01 means inside it, 11 means above it. code_valid is high for exactly the cycle after each sampling edge.
- R3: Each sample shifts the history one place. The newest code lands in hist_codes[1:0], entry k sits at hist_codes[2k+1:2k], and the oldest entry is dropped.
- R4: Edges without sample_en leave err_code, hist_codes and win_narrow unchanged.
- R5: win_narrow rises at the sampling edge whose code completes SETTLE_CNT consecutive in-window codes, counting the current one. Codes present before the first post-reset sample count as out of window.
- R6: win_narrow falls at the same edge that registers a 00 or 11 code.
- R7: narrow_ready rises READY_LAT clocks after win_narrow rises, provided win_narrow stays high. It falls together with win_narrow.
- R8: The input pair 10 is registered and stored as 01 and counts as in-window. It sets illegal_seen, which then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Sample strobe; comparator results are taken at this edge |
| above_hi | input | 1 | Feedback is above the upper reference |
| above_lo | input | 1 | Feedback is above the lower reference |
| err_code | output | 2 | Latest error code (00 below, 01 inside, 11 above) |
| code_valid | output | 1 | One-cycle pulse after each sample |
| hist_codes | output | 2*HIST_DEPTH | Code history, newest in the low bits |
| win_narrow | output | 1 | Reference multiplexer select: 1 selects the narrow pair |
| narrow_ready | output | 1 | Narrow window has had time to take effect |
| illegal_seen | output | 1 | Sticky flag for the impossible comparator pair |

## Verification
The bench uses HIST_DEPTH=4, SETTLE_CNT=2 and READY_LAT=2. With these values the history fills and starts dropping entries within four samples. Settling takes only two in-window samples, so random traffic weighted toward in-window codes moves the select back and forth many times. A two-clock ready delay is short enough that idle cycles between samples often let narrow_ready rise before an out-of-window code pulls it down. These settings also reach the cases where the ready flag is cut off early.

// File: rtl/adwin_pkg.sv
package adwin_pkg;
  localparam int CODE_W = 2;
  typedef logic [CODE_W-1:0] err_code_t;
  localparam err_code_t CODE_BELOW  = 2'b00;
  localparam err_code_t CODE_INSIDE = 2'b01;
  localparam err_code_t CODE_ABOVE  = 2'b11;
  localparam err_code_t CODE_BAD    = 2'b10;
endpackage

// File: rtl/adwin_code_map.sv
module adwin_code_map
  import adwin_pkg::*;
(
  input  logic      above_hi,
  input  logic      above_lo,
  output err_code_t code,
  output logic      in_win,
  output logic      bad_pair
);
  err_code_t raw;
  assign raw = {above_hi, above_lo};

  always_comb begin
    bad_pair = 1'b0;
    code     = raw;
    if (raw == CODE_BAD) begin
      code     = CODE_INSIDE;
      bad_pair = 1'b1;
    end
    in_win = (code == CODE_INSIDE);
  end
endmodule

// File: rtl/adwin_history.sv
module adwin_history
  import adwin_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  shift_en,
  input  err_code_t             din,
  output logic [CODE_W*DEPTH-1:0] hist_flat,
  output logic [DEPTH-1:0]      inwin
);
  err_code_t ent [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) ent[k] <= CODE_BELOW;
    end else if (shift_en) begin
      ent[0] <= din;
      for (int k = 1; k < DEPTH; k++) ent[k] <= ent[k-1];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_tap
    assign hist_flat[CODE_W*g +: CODE_W] = ent[g];
    assign inwin[g] = (ent[g] == CODE_INSIDE);
  end

  // R3: each older slot receives the previous contents of its neighbour
  if (DEPTH > 1) begin : g_chk
    a_r3_shift_order: assert property (@(posedge clk) disable iff (rst)
      shift_en |=> (ent[1] == $past(ent[0])));
  end
  a_r3_head_load: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (ent[0] == $past(din)));
endmodule

// File: rtl/adwin_window_ctrl.sv
module adwin_window_ctrl #(
  parameter int DEPTH     = 4,
  parameter int SETTLE    = 2,
  parameter int LAT       = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_en,
  input  logic             new_in_win,
  input  logic [DEPTH-1:0] inwin_hist,
  output logic             win_narrow,
  output logic             narrow_ready
);
  localparam int CNT_W = $clog2(LAT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LAT);

  logic             prior_ok;
  logic [CNT_W-1:0] age;

  if (SETTLE <= 1) begin : g_one
    assign prior_ok = 1'b1;
  end else begin : g_many
    assign prior_ok = &inwin_hist[SETTLE-2:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_narrow <= 1'b0;
    end else if (sample_en) begin
      if (!new_in_win)   win_narrow <= 1'b0;
      else if (prior_ok) win_narrow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !win_narrow) age <= '0;
    else if (age != CNT_MAX) age <= age + 1'b1;
  end

  assign narrow_ready = win_narrow && (age == CNT_MAX);

  // R7: ready never stands without the narrow select
  a_r7_ready_needs_sel: assert property (@(posedge clk) disable iff (rst)
    narrow_ready |-> win_narrow);
  // R6: an out-of-window sample drops the narrow select at once
  a_r6_fall_on_exit: assert property (@(posedge clk) disable iff (rst)
    (sample_en && !new_in_win) |=> !win_narrow);
  // R5: the select only rises on a sampling edge
  a_r5_rise_on_sample: assert property (@(posedge clk) disable iff (rst)
    $rose(win_narrow) |-> $past(sample_en));
endmodule

// File: rtl/adwin_ctrl.sv
module adwin_ctrl
  import adwin_pkg::*;
#(
  parameter int HIST_DEPTH = 4,
  parameter int SETTLE_CNT = 2,
  parameter int READY_LAT  = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sample_en,
  input  logic                         above_hi,
  input  logic                         above_lo,
  output logic [1:0]                   err_code,
  output logic                         code_valid,
  output logic [2*HIST_DEPTH-1:0]      hist_codes,
  output logic                         win_narrow,
  output logic                         narrow_ready,
  output logic                         illegal_seen
);
  err_code_t             cur_code;
  logic                  cur_in;
  logic                  cur_bad;
  logic [HIST_DEPTH-1:0] hist_in;

  adwin_code_map u_map (
    .above_hi (above_hi),
    .above_lo (above_lo),
    .code     (cur_code),
    .in_win   (cur_in),
    .bad_pair (cur_bad)
  );

  adwin_history #(.DEPTH(HIST_DEPTH)) u_hist (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (sample_en),
    .din       (cur_code),
    .hist_flat (hist_codes),
    .inwin     (hist_in)
  );

  adwin_window_ctrl #(
    .DEPTH  (HIST_DEPTH),
    .SETTLE (SETTLE_CNT),
    .LAT    (READY_LAT)
  ) u_win (
    .clk          (clk),
    .rst          (rst),
    .sample_en    (sample_en),
    .new_in_win   (cur_in),
    .inwin_hist   (hist_in),
    .win_narrow   (win_narrow),
    .narrow_ready (narrow_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_code     <= CODE_BELOW;
      code_valid   <= 1'b0;
      illegal_seen <= 1'b0;
    end else begin
      code_valid <= sample_en;
      if (sample_en) begin
        err_code <= cur_code;
        if (cur_bad) illegal_seen <= 1'b1;
      end
    end
  end

  // R8: the flag, once set, stays until reset
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    illegal_seen |=> illegal_seen);
  // R2: the forbidden code never leaves the block
  a_r2_legal_out: assert property (@(posedge clk) disable iff (rst)
    code_valid |-> (err_code != CODE_BAD));
  // R2: valid follows a sample strobe
  a_r2_valid_src: assert property (@(posedge clk) disable iff (rst)
    code_valid |-> $past(sample_en));
  // R4: idle edges keep code, history and select
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !sample_en |=> ($stable(err_code) && $stable(hist_codes) && $stable(win_narrow)));
endmodule

// File: tb/adwin_ctrl_bench.sv
`timescale 1ns/1ps
module adwin_ctrl_bench;
  localparam int HD = 4;
  localparam int ST = 2;
  localparam int LT = 2;

  logic clk = 1'b0, rst = 1'b1, se = 1'b0, hi = 1'b0, lo = 1'b0;
  logic [1:0]      err_code;
  logic            code_valid;
  logic [2*HD-1:0] hist_codes;
  logic            win_narrow, narrow_ready, illegal_seen;

  adwin_ctrl #(.HIST_DEPTH(HD), .SETTLE_CNT(ST), .READY_LAT(LT)) u_adwin_ctrl (
    .clk(clk), .rst(rst), .sample_en(se), .above_hi(hi), .above_lo(lo),
    .err_code(err_code), .code_valid(code_valid), .hist_codes(hist_codes),
    .win_narrow(win_narrow), .narrow_ready(narrow_ready), .illegal_seen(illegal_seen)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [1:0] m_hist [HD];
  logic [1:0] m_code;
  logic       m_valid, m_win, m_ill;
  int         m_run, m_cnt;

  function automatic logic [2*HD-1:0] flat_hist();
    logic [2*HD-1:0] f;
    for (int k = 0; k < HD; k++) f[2*k +: 2] = m_hist[k];
    return f;
  endfunction

  function automatic logic [1:0] map_pair(logic h, logic l);
    return ({h, l} == 2'b10) ? 2'b01 : {h, l};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int nc;
    logic [1:0] c;
    if (rst) begin
      for (int k = 0; k < HD; k++) m_hist[k] = 2'b00;
      m_code = 2'b00; m_valid = 0; m_win = 0; m_ill = 0; m_run = 0; m_cnt = 0;
    end else begin
      nc = m_win ? ((m_cnt < LT) ? m_cnt + 1 : LT) : 0;
      m_valid = se;
      if (se) begin
        c = map_pair(hi, lo);
        if ({hi, lo} == 2'b10) m_ill = 1;
        for (int k = HD - 1; k > 0; k--) m_hist[k] = m_hist[k-1];
        m_hist[0] = c;
        m_code = c;
        if (c == 2'b01) m_run = (m_run < ST) ? m_run + 1 : ST;
        else m_run = 0;
        if (c != 2'b01) m_win = 0;
        else if (m_run >= ST) m_win = 1;
      end
      m_cnt = nc;
    end
  endtask

  task automatic check_all();
    logic exp_rdy;
    exp_rdy = m_win && (m_cnt == LT);
    chk(err_code == m_code, "R2 err_code", err_code, m_code);
    chk(code_valid == m_valid, "R2 code_valid", code_valid, m_valid);
    chk(hist_codes == flat_hist(), "R3 history", hist_codes, flat_hist());
    chk(win_narrow == m_win, "R5 R6 win_narrow", win_narrow, m_win);
    chk(narrow_ready == exp_rdy, "R7 narrow_ready", narrow_ready, exp_rdy);
    chk(illegal_seen == m_ill, "R8 illegal_seen", illegal_seen, m_ill);
  endtask

  task automatic cycle(input logic r, input logic s, input logic h, input logic l);
    rst = r; se = s; hi = h; lo = l;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all();
  endtask

  task automatic check_reset_state();
    chk(err_code == 2'b00 && code_valid == 0, "R1 code cleared", {err_code, code_valid}, 0);
    chk(hist_codes == '0, "R1 history cleared", hist_codes, 0);
    chk(!win_narrow && !narrow_ready && !illegal_seen, "R1 flags cleared",
        {win_narrow, narrow_ready, illegal_seen}, 0);
  endtask

  initial begin
    logic [2*HD-1:0] saved;
    void'($urandom(32'h1F2E3D4C));
    @(negedge clk);
    cycle(1, 0, 0, 0); cycle(1, 0, 0, 0);
    check_reset_state();
    // R2 each legal code
    cycle(0, 1, 1, 1); chk(err_code == 2'b11, "R2 above", err_code, 3);
    cycle(0, 1, 0, 0); chk(err_code == 2'b00, "R2 below", err_code, 0);
    cycle(0, 1, 0, 1); chk(!win_narrow, "R5 one in-window not enough", win_narrow, 0);
    // R4 idle edges hold state
    saved = hist_codes;
    cycle(0, 0, 1, 1); cycle(0, 0, 0, 0);
    chk(hist_codes == saved && err_code == 2'b01, "R4 idle hold", hist_codes, saved);
    cycle(0, 1, 0, 1); chk(win_narrow, "R5 select after settle", win_narrow, 1);
    chk(!narrow_ready, "R7 not ready at rise", narrow_ready, 0);
    cycle(0, 0, 0, 0); chk(!narrow_ready, "R7 not ready after one clock", narrow_ready, 0);
    cycle(0, 0, 0, 0); chk(narrow_ready, "R7 ready after two clocks", narrow_ready, 1);
    cycle(0, 1, 1, 1); chk(!win_narrow && !narrow_ready, "R6 fall on above", win_narrow, 0);
    // R8 illegal pair counts as inside
    cycle(0, 1, 1, 0); chk(err_code == 2'b01 && illegal_seen, "R8 illegal mapped", err_code, 1);
    cycle(0, 1, 0, 1); chk(win_narrow, "R8 illegal counts toward settle", win_narrow, 1);
    cycle(0, 1, 0, 0); chk(!win_narrow && illegal_seen, "R6 R8 fall on below, flag sticks",
                           {win_narrow, illegal_seen}, 1);
    // random traffic
    for (int i = 0; i < 600; i++) begin
      int r;
      logic s, h, l;
      s = ($urandom % 4) != 0;
      r = $urandom % 16;
      if (r < 9)       begin h = 0; l = 1; end
      else if (r < 12) begin h = 0; l = 0; end
      else if (r < 15) begin h = 1; l = 1; end
      else             begin h = 1; l = 0; end
      cycle(($urandom % 200) == 0, s, h, l);
    end
    cycle(1, 1, 1, 0);
    check_reset_state();
    cycle(0, 0, 0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule